// File: doc/BRIEF.md
# Multichannel RC Pulse-Frame and Servo Generator

The block turns a set of 16-bit channel words into a radio-control pulse train on one pin. Each channel occupies a slot. The slot opens with a rising edge and a fixed-width high pulse, then stays low until the next slot opens. The distance from one rising edge to the next carries the channel value, scaled linearly between a minimum and a maximum period. After the last slot, a long low gap separates one frame from the next. The same slot boundaries can also drive one servo-style output per channel. Each servo output is high for the whole of its own slot. Channels configured without a servo output keep that pin low.

A controller loads values one channel at a time through an indexed write port, or all at once through a wide word with its own strobe. Values are copied into the running set only when a sync gap begins, so a frame never mixes old and new settings. Nothing is driven until every channel has been loaded. A release input stops the block and clears its outputs, unless the block is built in persistent mode. All times count pulses of an external one-microsecond tick. Channel count, period limits, pause width, sync gap, the servo map and the output modes are parameters.

Top module: `rc_frame_gen`

## Requirements
- R1: A channel word v gives a slot of MIN_US + floor(v * (MAX_US - MIN_US) / 65535) ticks, measured from the rising edge of `ppm_out` that opens the slot to the rising edge that opens the next one. A word of 0 gives MIN_US and a word of 65535 gives MAX_US.
- R2: Every slot begins with `ppm_out` high for exactly PAUSE_US ticks. The output is low for the rest of the slot.
- R3: After the last channel slot comes a low sync gap of SYNC_US ticks. The low run that follows the last pulse therefore lasts (last slot - PAUSE_US + SYNC_US) ticks, and the frame period is the sum of the slots plus SYNC_US.
- R4: `servo_out[k]` is high for the whole of slot k only when bit k of SERVO_MASK is set. It is low during the sync gap and during other slots. At most one servo output is high at a time.
- R5: Bits [16k+15:16k] of `all_data` load channel k, and `all_en` loads every channel in the same cycle. Writes made during a frame do not change that frame. Loaded values take effect at the start of the next sync gap.
- R6: No output leaves 0 until every channel has been loaded since reset or release. A `wr_en` write with `wr_idx` >= N_CH is ignored.
- R7: With PERSIST = 0, a `host_release` pulse drives all outputs to 0 on the next clock edge and keeps them at 0. It also forgets every loaded channel, so all channels must be loaded again before output resumes.
- R8: With PERSIST = 1, `host_release` has no effect and the outputs keep running.
- R9: With PPM_EN = 0, `ppm_out` stays at 0 while the servo outputs still run (servo-only mode).
- R10: While `rst_n` is low, all outputs are 0.
- R11: Timing advances only in cycles where `us_tick` is high. Outputs change only on a tick cycle or in the cycle after a release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| wr_en | input | 1 | Single-channel write strobe |
| wr_idx | input | IDX_W | Channel index for the single write |
| wr_data | input | 16 | Channel word for the single write |
| all_en | input | 1 | Strobe that loads all channels together |
| all_data | input | 16*N_CH | Channel k in bits [16k+15:16k] |
| host_release | input | 1 | Controller release pulse |
| ppm_out | output | 1 | Multiplexed pulse-position frame |
| servo_out | output | N_CH | Per-channel servo pulses |

## Verification
The hardest situation to reach is the handover at the frame boundary. New words must land in the shadow copy while the frame in flight keeps its old values, and then appear exactly one frame later. The stimulus writes random words, sometimes one channel and sometimes all at once, during the first pulse of every measured frame. It then measures each slot of that frame against the previous words and the next frame against the new ones. A release is issued in the middle of a running frame, followed by a partial reload that must keep the pins low. A second instance built as persistent and servo-only sees the same release and must keep running.

// File: rtl/rc_frame_pkg.sv
package rc_frame_pkg;
   localparam int WORD_W = 16;
   localparam int WORD_FULL = 65535;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_SYNC = 2'd1,
      PH_HIGH = 2'd2,
      PH_LOW  = 2'd3
   } phase_t;
endpackage

// File: rtl/rc_chan_regs.sv
module rc_chan_regs
   import rc_frame_pkg::*;
#(
   parameter int N_CH  = 6,
   parameter int IDX_W = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [IDX_W-1:0]              wr_idx,
   input  logic [WORD_W-1:0]             wr_data,
   input  logic                          all_en,
   input  logic [N_CH*WORD_W-1:0]        all_data,
   input  logic                          clr,
   input  logic                          latch,
   output logic [N_CH-1:0][WORD_W-1:0]   act_val,
   output logic                          all_written
);
   logic [N_CH-1:0][WORD_W-1:0] shadow;
   logic [N_CH-1:0]             written;
   logic                        idx_ok;

   assign idx_ok      = int'(wr_idx) < N_CH;
   assign all_written = &written;

   genvar k;
   generate
      for (k = 0; k < N_CH; k++) begin : g_ch
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               shadow[k]  <= '0;
               written[k] <= 1'b0;
            end else begin
               if (all_en) begin
                  shadow[k] <= all_data[k*WORD_W +: WORD_W];
               end else if (wr_en && idx_ok && (int'(wr_idx) == k)) begin
                  shadow[k] <= wr_data;
               end
               if (clr) begin
                  written[k] <= 1'b0;
               end else if (all_en || (wr_en && idx_ok && (int'(wr_idx) == k))) begin
                  written[k] <= 1'b1;
               end
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               act_val[k] <= '0;
            end else if (latch) begin
               act_val[k] <= shadow[k];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/rc_map.sv
module rc_map
   import rc_frame_pkg::*;
#(
   parameter int MIN_US = 1000,
   parameter int MAX_US = 2000,
   parameter int CNT_W  = 14
) (
   input  logic [WORD_W-1:0] val,
   output logic [CNT_W-1:0]  len
);
   localparam int SPAN   = MAX_US - MIN_US;
   localparam int PROD_W = WORD_W + 32;

   logic [PROD_W-1:0] prod;
   logic [PROD_W-1:0] quo;

   assign prod = PROD_W'(val) * PROD_W'(SPAN);
   assign quo  = prod / PROD_W'(WORD_FULL);
   assign len  = CNT_W'(quo) + CNT_W'(MIN_US);
endmodule

// File: rtl/rc_sequencer.sv
module rc_sequencer
   import rc_frame_pkg::*;
#(
   parameter int N_CH     = 6,
   parameter int IDX_W    = 3,
   parameter int CNT_W    = 14,
   parameter int PAUSE_US = 500,
   parameter int SYNC_US  = 12000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             armed,
   input  logic             clr,
   input  logic [CNT_W-1:0] cur_len,
   output phase_t           phase,
   output logic [IDX_W-1:0] ch,
   output logic             latch
);
   localparam logic [IDX_W-1:0] LAST_CH  = IDX_W'(N_CH - 1);
   localparam logic [CNT_W-1:0] SYNC_RLD = CNT_W'(SYNC_US - 1);
   localparam logic [CNT_W-1:0] HIGH_RLD = CNT_W'(PAUSE_US - 1);
   localparam logic [CNT_W-1:0] LOW_SUB  = CNT_W'(PAUSE_US + 1);

   phase_t           phase_nx;
   logic [IDX_W-1:0] ch_nx;
   logic [CNT_W-1:0] rem, rem_nx;

   always_comb begin
      phase_nx = phase;
      ch_nx    = ch;
      rem_nx   = rem;
      latch    = 1'b0;
      if (clr) begin
         phase_nx = PH_IDLE;
         ch_nx    = '0;
         rem_nx   = '0;
      end else if (phase == PH_IDLE) begin
         if (armed) begin
            phase_nx = PH_SYNC;
            rem_nx   = SYNC_RLD;
            latch    = 1'b1;
         end
      end else if (tick) begin
         if (rem != '0) begin
            rem_nx = rem - 1'b1;
         end else begin
            case (phase)
               PH_SYNC: begin
                  phase_nx = PH_HIGH;
                  ch_nx    = '0;
                  rem_nx   = HIGH_RLD;
               end
               PH_HIGH: begin
                  phase_nx = PH_LOW;
                  rem_nx   = cur_len - LOW_SUB;
               end
               PH_LOW: begin
                  if (ch == LAST_CH) begin
                     phase_nx = PH_SYNC;
                     rem_nx   = SYNC_RLD;
                     latch    = 1'b1;
                  end else begin
                     phase_nx = PH_HIGH;
                     ch_nx    = ch + 1'b1;
                     rem_nx   = HIGH_RLD;
                  end
               end
               default: phase_nx = PH_IDLE;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         ch    <= '0;
         rem   <= '0;
      end else begin
         phase <= phase_nx;
         ch    <= ch_nx;
         rem   <= rem_nx;
      end
   end
endmodule

// File: rtl/rc_out_stage.sv
module rc_out_stage
   import rc_frame_pkg::*;
#(
   parameter int              N_CH       = 6,
   parameter int              IDX_W      = 3,
   parameter logic [N_CH-1:0] SERVO_MASK = '1,
   parameter bit              PPM_EN     = 1'b1
) (
   input  phase_t           phase,
   input  logic [IDX_W-1:0] ch,
   output logic             ppm_out,
   output logic [N_CH-1:0]  servo_out
);
   logic in_slot;
   assign in_slot = (phase == PH_HIGH) || (phase == PH_LOW);

   generate
      if (PPM_EN) begin : g_ppm
         assign ppm_out = (phase == PH_HIGH);
      end else begin : g_no_ppm
         assign ppm_out = 1'b0;
      end
   endgenerate

   genvar k;
   generate
      for (k = 0; k < N_CH; k++) begin : g_servo
         if (SERVO_MASK[k]) begin : g_on
            assign servo_out[k] = in_slot && (ch == IDX_W'(k));
         end else begin : g_off
            assign servo_out[k] = 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/rc_frame_gen.sv
module rc_frame_gen
   import rc_frame_pkg::*;
#(
   parameter int              N_CH       = 6,
   parameter int              MIN_US     = 1000,
   parameter int              MAX_US     = 2000,
   parameter int              PAUSE_US   = 500,
   parameter int              SYNC_US    = 12000,
   parameter logic [N_CH-1:0] SERVO_MASK = '1,
   parameter bit              PPM_EN     = 1'b1,
   parameter bit              PERSIST    = 1'b0,
   localparam int             IDX_W      = (N_CH > 1) ? $clog2(N_CH) : 1,
   localparam int             SPAN_MAX   = (MAX_US > SYNC_US) ? MAX_US : SYNC_US,
   localparam int             CNT_W      = $clog2(SPAN_MAX + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     us_tick,
   input  logic                     wr_en,
   input  logic [IDX_W-1:0]         wr_idx,
   input  logic [15:0]              wr_data,
   input  logic                     all_en,
   input  logic [N_CH*16-1:0]       all_data,
   input  logic                     host_release,
   output logic                     ppm_out,
   output logic [N_CH-1:0]          servo_out
);
   generate
      if (N_CH < 1 || PAUSE_US < 1 || SYNC_US < 1) begin : g_bad_size
         $error("rc_frame_gen: channel count, pause and sync must be positive");
      end
      if (MIN_US <= PAUSE_US || MAX_US < MIN_US) begin : g_bad_range
         $error("rc_frame_gen: need PAUSE_US < MIN_US <= MAX_US");
      end
   endgenerate

   logic [N_CH-1:0][WORD_W-1:0] act_val;
   logic [N_CH-1:0][CNT_W-1:0]  len;
   logic                        all_written;
   logic                        latch;
   logic                        clr;
   phase_t                      phase;
   logic [IDX_W-1:0]            ch;
   logic [CNT_W-1:0]            cur_len;

   generate
      if (PERSIST) begin : g_persist
         assign clr = 1'b0;
      end else begin : g_release
         assign clr = host_release;
      end
   endgenerate

   rc_chan_regs #(.N_CH(N_CH), .IDX_W(IDX_W)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_idx      (wr_idx),
      .wr_data     (wr_data),
      .all_en      (all_en),
      .all_data    (all_data),
      .clr         (clr),
      .latch       (latch),
      .act_val     (act_val),
      .all_written (all_written)
   );

   genvar k;
   generate
      for (k = 0; k < N_CH; k++) begin : g_map
         rc_map #(.MIN_US(MIN_US), .MAX_US(MAX_US), .CNT_W(CNT_W)) u_map (
            .val (act_val[k]),
            .len (len[k])
         );
      end
   endgenerate

   assign cur_len = len[ch];

   rc_sequencer #(
      .N_CH(N_CH), .IDX_W(IDX_W), .CNT_W(CNT_W),
      .PAUSE_US(PAUSE_US), .SYNC_US(SYNC_US)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (us_tick),
      .armed   (all_written),
      .clr     (clr),
      .cur_len (cur_len),
      .phase   (phase),
      .ch      (ch),
      .latch   (latch)
   );

   rc_out_stage #(
      .N_CH(N_CH), .IDX_W(IDX_W), .SERVO_MASK(SERVO_MASK), .PPM_EN(PPM_EN)
   ) u_out (
      .phase     (phase),
      .ch        (ch),
      .ppm_out   (ppm_out),
      .servo_out (servo_out)
   );
endmodule

// File: rtl/rc_frame_gen_chk.sv
module rc_frame_gen_chk #(
   parameter int N_CH    = 6,
   parameter bit PERSIST = 1'b0
) (
   input logic            clk,
   input logic            rst_n,
   input logic            us_tick,
   input logic            host_release,
   input logic            armed,
   input logic            ppm_out,
   input logic [N_CH-1:0] servo_out
);
   assert_servo_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(servo_out));

   assert_quiet_until_loaded_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> (!ppm_out && servo_out == '0));

   assert_tick_paced_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ppm_out != $past(ppm_out) || servo_out != $past(servo_out))
         |-> ($past(us_tick) || $past(host_release)));

   generate
      if (PERSIST) begin : g_persist
         assert_release_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (host_release && armed) |=> armed);
      end else begin : g_release
         assert_release_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
            host_release |=> (!ppm_out && servo_out == '0 && !armed));
      end
   endgenerate
endmodule

bind rc_frame_gen rc_frame_gen_chk #(.N_CH(N_CH), .PERSIST(PERSIST)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .us_tick      (us_tick),
   .host_release (host_release),
   .armed        (all_written),
   .ppm_out      (ppm_out),
   .servo_out    (servo_out)
);

// File: tb/rc_frame_gen_bench.sv
module rc_frame_gen_bench;
   localparam int NB    = 5;
   localparam int TMIN  = 20;
   localparam int TMAX  = 40;
   localparam int TPAU  = 6;
   localparam int TSYN  = 50;
   localparam logic [NB-1:0] MASK = 5'b11011;
   localparam int IW    = 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            us_tick = 1'b0;
   logic            wr_en = 1'b0;
   logic [IW-1:0]   wr_idx = '0;
   logic [15:0]     wr_data = '0;
   logic            all_en = 1'b0;
   logic [NB*16-1:0] all_data = '0;
   logic            host_release = 1'b0;
   logic            ppm_out, ppm2;
   logic [NB-1:0]   servo_out, servo2;

   int checks = 0;
   int fails  = 0;
   int cur [NB];
   int nxt [NB];

   always #4 clk = ~clk;

   always @(negedge clk) begin
      if (!rst_n) us_tick <= 1'b0;
      else        us_tick <= ~us_tick;
   end

   rc_frame_gen #(
      .N_CH(NB), .MIN_US(TMIN), .MAX_US(TMAX), .PAUSE_US(TPAU), .SYNC_US(TSYN),
      .SERVO_MASK(MASK), .PPM_EN(1'b1), .PERSIST(1'b0)
   ) u_rc_frame_gen (
      .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .all_en(all_en), .all_data(all_data),
      .host_release(host_release), .ppm_out(ppm_out), .servo_out(servo_out)
   );

   rc_frame_gen #(
      .N_CH(NB), .MIN_US(TMIN), .MAX_US(TMAX), .PAUSE_US(TPAU), .SYNC_US(TSYN),
      .SERVO_MASK('1), .PPM_EN(1'b0), .PERSIST(1'b1)
   ) u_rc_frame_gen_persist (
      .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .all_en(all_en), .all_data(all_data),
      .host_release(host_release), .ppm_out(ppm2), .servo_out(servo2)
   );

   function automatic int exp_len(input int v);
      longint p;
      p = longint'(v) * longint'(TMAX - TMIN);
      return TMIN + int'(p / 65535);
   endfunction

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic next_tick();
      do @(posedge clk); while (us_tick !== 1'b1);
      #1;
   endtask

   task automatic wr1(input int idx, input int val);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = IW'(idx); wr_data = 16'(val);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wr_all(input int v [NB]);
      @(negedge clk);
      for (int k = 0; k < NB; k++) all_data[k*16 +: 16] = 16'(v[k]);
      all_en = 1'b1;
      @(negedge clk);
      all_en = 1'b0;
   endtask

   task automatic find_rise();
      while (ppm_out !== 1'b1) next_tick();
   endtask

   // Entered on the first high sample of slot 0; leaves on the first high
   // sample of the next frame.
   task automatic check_frame(input int vals [NB]);
      int hi, lo, len, smis;
      logic [NB-1:0] se, ex;
      smis = 0;
      for (int k = 0; k < NB; k++) begin
         len = exp_len(vals[k]);
         se  = MASK & (NB'(1) << k);
         hi  = 1;
         if (servo_out !== se) smis++;
         while (1) begin
            next_tick();
            if (ppm_out !== 1'b1) break;
            hi++;
            if (servo_out !== se) smis++;
         end
         lo = 1;
         if (servo_out !== se) smis++;
         while (1) begin
            next_tick();
            if (ppm_out !== 1'b0) break;
            ex = (k < NB - 1 || lo < len - TPAU) ? se : '0;
            if (servo_out !== ex) smis++;
            lo++;
         end
         chk(hi == TPAU, "R2 pause width", hi, TPAU);
         if (k < NB - 1)
            chk(hi + lo == len, "R1 R11 slot length", hi + lo, len);
         else
            chk(lo == len - TPAU + TSYN, "R3 last low run with sync", lo, len - TPAU + TSYN);
      end
      chk(smis == 0, "R4 servo samples", smis, 0);
   endtask

   task automatic apply_update(input int f);
      int idx;
      if (f == 2) begin
         nxt[0] = 0; nxt[1] = 65535; nxt[2] = 1; nxt[3] = 65534; nxt[4] = 32768;
      end else if (f % 4 == 0) begin
         for (int k = 0; k < NB; k++) nxt[k] = int'($urandom % 65536);
      end else if (f % 4 == 1) begin
         idx = int'($urandom % NB);
         nxt[idx] = int'($urandom % 65536);
         fork
            begin
               automatic int ii = idx;
               automatic int vv = nxt[idx];
               wr1(ii, vv);
            end
         join_none
         return;
      end else begin
         return;
      end
      fork
         begin
            automatic int cp [NB] = nxt;
            wr_all(cp);
         end
      join_none
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      int bad, act2;
      void'($urandom(32'h5eed_0c11));
      repeat (4) @(posedge clk);
      #1;
      // R10: reset state
      chk(ppm_out === 1'b0 && servo_out === '0, "R10 reset outputs", {servo_out, ppm_out}, 0);
      chk(ppm2 === 1'b0 && servo2 === '0, "R10 reset outputs persist", {servo2, ppm2}, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R6: partial load plus out-of-range indices keeps outputs quiet
      for (int k = 0; k < NB - 1; k++) begin
         cur[k] = int'($urandom % 65536);
         wr1(k, cur[k]);
      end
      wr1(5, 1234); wr1(6, 77); wr1(7, 65535);
      bad = 0;
      repeat (150) begin
         next_tick();
         if (ppm_out !== 1'b0 || servo_out !== '0 || servo2 !== '0) bad++;
      end
      chk(bad == 0, "R6 quiet before all channels loaded", bad, 0);
      cur[NB-1] = 40000;
      wr1(NB - 1, cur[NB-1]);
      nxt = cur;
      find_rise();

      // R1 R2 R3 R4 R5: frames with writes made during slot 0
      for (int f = 0; f < 22; f++) begin
         apply_update(f);
         check_frame(cur);   // R5: in-flight frame keeps old values
         cur = nxt;
      end

      // R7: release mid-frame
      next_tick();
      @(negedge clk);
      host_release = 1'b1;
      @(negedge clk);
      host_release = 1'b0;
      #1;
      chk(ppm_out === 1'b0 && servo_out === '0, "R7 outputs cleared after release",
          {servo_out, ppm_out}, 0);
      bad = 0; act2 = 0;
      repeat (150) begin
         next_tick();
         if (ppm_out !== 1'b0 || servo_out !== '0) bad++;
         if (servo2 !== '0) act2++;
         if (ppm2 !== 1'b0) bad++;
      end
      chk(bad == 0, "R7 R9 held low after release", bad, 0);
      chk(act2 > 0, "R8 persistent instance keeps running", act2, 1);

      // R7: partial reload after release is not enough
      for (int k = 0; k < NB - 1; k++) wr1(k, 100 * k);
      bad = 0;
      repeat (120) begin
         next_tick();
         if (ppm_out !== 1'b0 || servo_out !== '0) bad++;
      end
      chk(bad == 0, "R7 reload of every channel required", bad, 0);

      // R5: one-step load re-arms with all-new values
      for (int k = 0; k < NB; k++) nxt[k] = 65535 - 9000 * k;
      begin
         automatic int cp [NB] = nxt;
         wr_all(cp);
      end
      cur = nxt;
      find_rise();
      check_frame(cur);
      bad = 0;
      repeat (300) begin
         next_tick();
         if (ppm2 !== 1'b0) bad++;
      end
      chk(bad == 0, "R9 servo-only pin stays low", bad, 0);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule